// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair

This block runs integer multiplication and division over several clock cycles and keeps the outcome in a dedicated pair of result registers, called HI and LO here. A single start strobe launches one of four operations on two operands: signed multiply, unsigned multiply, signed divide and unsigned divide. The multiplier is a shift-add engine and the divider a restoring engine. Each retires one operand bit per cycle, so one operation takes WIDTH steps plus one cycle to write the result.

A multiply writes the double-width product across the pair, with the upper half in HI and the lower half in LO. A divide writes the quotient into LO and the remainder into HI. Neither operation ever signals an overflow. Both registers are always visible on read ports, so move-from-HI and move-from-LO are plain reads. A busy flag tells the issuing pipeline when the pair holds a fresh result. While the unit is busy the read ports keep returning the previous result, and a new start request is dropped.

Top module: `md_unit`

## Requirements
- R1: After reset, hi_o and lo_o read zero and busy_o is low.
- R2: op_i = 1 (unsigned multiply) leaves {hi_o, lo_o} equal to the unsigned product of a_i and b_i, with the upper WIDTH bits in hi_o.
- R3: op_i = 0 (signed multiply) treats both operands as two's complement and leaves {hi_o, lo_o} equal to the full two's complement product.
- R4: op_i = 3 (unsigned divide) with b_i nonzero leaves the quotient a_i / b_i in lo_o and the remainder in hi_o.
- R5: op_i = 2 (signed divide) with b_i nonzero truncates the quotient toward zero and gives the remainder the sign of the dividend. The most negative value divided by -1 wraps to a quotient equal to the most negative value, with remainder zero.
- R6: A divide of either kind with b_i = 0 completes normally with lo_o all ones and hi_o equal to a_i.
- R7: A start_i sampled while busy_o is low is accepted. busy_o is high from the next cycle for exactly WIDTH+1 cycles, and the result is visible in the cycle busy_o falls.
- R8: hi_o and lo_o change only in the cycle busy_o falls. While busy_o is high they hold the previous result.
- R9: A start_i sampled while busy_o is high is ignored: the running operation's result and busy length are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request |
| op_i | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | Operation in flight |
| hi_o | output | WIDTH | HI register: product upper half or remainder |
| lo_o | output | WIDTH | LO register: product lower half or quotient |

## Verification
Two functions can meet in one cycle: a new start request landing while an operation is in flight, and the final write of the result pair together with the fall of busy. The bench injects a second start with different operands partway through an operation. It then checks that the written result belongs to the first operands and that the busy window still lasts WIDTH+1 cycles. On every operation it also watches that the read ports hold their old value until the cycle busy drops.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    MD_MUL  = 2'd0,
    MD_MULU = 2'd1,
    MD_DIV  = 2'd2,
    MD_DIVU = 2'd3
  } md_op_e;
endpackage

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [2*WIDTH-1:0] acc_q;
  logic [WIDTH-1:0]   mc_q;
  logic [CW-1:0]      cnt_q;
  logic               done_q;
  logic [WIDTH:0]     sum;

  // upper half accumulates, lower half shifts the multiplier out
  always_comb begin
    sum = {1'b0, acc_q[2*WIDTH-1:WIDTH]} + (acc_q[0] ? {1'b0, mc_q} : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mc_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= {{WIDTH{1'b0}}, mplier_i};
      mc_q   <= mcand_i;
      cnt_q  <= CW'(WIDTH);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q  <= {sum, acc_q[WIDTH-1:1]};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic             done_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [WIDTH:0]   shifted, diff;
  logic             fit;

  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    diff    = shifted - {1'b0, dvs_q};
    fit     = ~diff[WIDTH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dvd_i;
      dvs_q  <= dvs_i;
      cnt_q  <= CW'(WIDTH);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fit ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
      quo_q  <= {quo_q[WIDTH-2:0], fit};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int unsigned PW = 2 * WIDTH;

  md_op_e op;
  logic go, is_div, signed_op, a_neg, b_neg;
  logic [WIDTH-1:0] mag_a, mag_b;

  logic busy_q, is_div_q, neg_p_q, neg_r_q, dz_q;
  logic [WIDTH-1:0] dvd_q, hi_q, lo_q;

  logic mul_done, div_done, done;
  logic [PW-1:0] prod, prod_fix;
  logic [WIDTH-1:0] quo, rem, quo_fix, rem_fix;

  always_comb begin
    op        = md_op_e'(op_i);
    go        = start_i & ~busy_q;
    is_div    = op_i[1];
    signed_op = (op == MD_MUL) || (op == MD_DIV);
    a_neg     = signed_op & a_i[WIDTH-1];
    b_neg     = signed_op & b_i[WIDTH-1];
    mag_a     = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b     = b_neg ? (~b_i + 1'b1) : b_i;
  end

  md_mul_core #(.WIDTH(WIDTH)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go & ~is_div),
    .mcand_i (mag_a),
    .mplier_i(mag_b),
    .done_o  (mul_done),
    .prod_o  (prod)
  );

  md_div_core #(.WIDTH(WIDTH)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go & is_div),
    .dvd_i  (mag_a),
    .dvs_i  (mag_b),
    .done_o (div_done),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  // sign restoration on the magnitude results
  always_comb begin
    done     = is_div_q ? div_done : mul_done;
    prod_fix = neg_p_q ? (~prod + 1'b1) : prod;
    quo_fix  = neg_p_q ? (~quo + 1'b1) : quo;
    rem_fix  = neg_r_q ? (~rem + 1'b1) : rem;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      is_div_q <= 1'b0;
      neg_p_q  <= 1'b0;
      neg_r_q  <= 1'b0;
      dz_q     <= 1'b0;
      dvd_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (go) begin
      busy_q   <= 1'b1;
      is_div_q <= is_div;
      neg_p_q  <= a_neg ^ b_neg;
      neg_r_q  <= a_neg;
      dz_q     <= (b_i == '0);
      dvd_q    <= a_i;
    end else if (busy_q && done) begin
      busy_q <= 1'b0;
      if (!is_div_q) begin
        {hi_q, lo_q} <= prod_fix;
      end else if (dz_q) begin
        hi_q <= dvd_q;
        lo_q <= '1;
      end else begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end
    end
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  localparam int unsigned CW = $clog2(WIDTH + 3);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (busy_o)  busy_cnt <= busy_cnt + 1'b1;
    else              busy_cnt <= '0;
  end

  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R7
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == CW'(WIDTH + 1)); // R7
  AST_BUSY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= CW'(WIDTH + 1)); // R9
  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> $stable(hi_o) && $stable(lo_o)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) && !busy_o |-> $stable(hi_o) && $stable(lo_o)); // R8
endmodule

bind md_unit md_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/sim_md_unit.sv
module sim_md_unit;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [W-1:0] a = '0, b = '0;
  logic busy;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  md_unit #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .hi_o(hi), .lo_o(lo)
  );

  function automatic int sx(input int v);
    return (v >= M/2) ? v - M : v;
  endfunction

  task automatic expect_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation; inject>0 issues an extra start that many cycles in
  task automatic run_op(input int o, input int x, input int y, input int inject);
    int eh, el, p, n;
    bit held;
    string req;
    logic [W-1:0] old_hi, old_lo;
    case (o)
      0: begin p = sx(x) * sx(y); eh = (p >> W) & (M-1); el = p & (M-1); req = "R3"; end
      1: begin p = x * y; eh = (p >> W) & (M-1); el = p & (M-1); req = "R2"; end
      2: begin
        if (y == 0) begin eh = x; el = M-1; req = "R6"; end
        else begin el = (sx(x) / sx(y)) & (M-1); eh = (sx(x) % sx(y)) & (M-1); req = "R5"; end
      end
      default: begin
        if (y == 0) begin eh = x; el = M-1; req = "R6"; end
        else begin el = x / y; eh = x % y; req = "R4"; end
      end
    endcase
    if (inject > 0) req = {req, "/R9"};
    @(negedge clk);
    old_hi = hi; old_lo = lo;
    start = 1'b1; op = 2'(o); a = W'(x); b = W'(y);
    @(negedge clk);
    start = 1'b0;
    n = 0; held = 1;
    while (busy) begin
      if (hi !== old_hi || lo !== old_lo) held = 0;
      if (inject > 0 && n == inject) begin
        start = 1'b1; op = 2'(3 - o); a = W'(~x); b = W'(y + 1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    expect_val("R8 hold while busy", int'(held), 1);
    expect_val("R7 busy length", n, W + 1);
    expect_val({req, " hi"}, int'(hi), eh);
    expect_val({req, " lo"}, int'(lo), el);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_val("R1 busy", int'(busy), 0);
    expect_val("R1 hi", int'(hi), 0);
    expect_val("R1 lo", int'(lo), 0);
    rst_n = 1'b1;
    // full sweep of all operations and operand pairs
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < M; x++)
        for (int y = 0; y < M; y++)
          run_op(o, x, y, 0);
    // corner cases: most negative over -1, divide by zero both kinds
    run_op(2, M/2, M-1, 0);
    run_op(2, M-3, 0, 0);
    run_op(3, M-1, 0, 0);
    // start request while busy, at several positions in the window
    for (int k = 1; k <= W; k++) begin
      run_op(k % 4, 5 + k, 3, k);
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule